// File: doc/BRIEF.md
# Keyed Watchdog Reset Gate

This block sits on the path from a watchdog's timeout output to the system reset controller and decides whether a timeout becomes a system reset request. Software controls the decision through a 4-bit keyed mask code, written over a simple write port in the platform clock domain. Exactly one code, `4'b0101`, suppresses the reset. Every other written value is replaced by the pass code `4'b1010`, so a stray or corrupted write can never leave the mask in an undefined state. A read returns the stored code after that replacement.

The mask decision moves through two flop stages in the platform domain and then two synchronizer stages in the peripheral domain before it reaches the gate. A change of mask setting therefore takes effect a few cycles late. The gate sees the timeout as a level and acts only on its rising edge. The watchdog decides at half-second granularity, so each edge is a distinct timeout event. Every timeout edge sets a sticky event flag, whether the reset is masked or not. The flag is synchronized back to the platform domain for software to read, and only the hardware reset clears it. The reset request is a registered output. Once raised, it holds until the hardware reset arrives.

Because only an edge counts, a timeout that is already pending when software lifts the mask does not cause a reset. The watchdog has to be serviced and has to time out again.

Top module: `wdm_keyed_gate`

## Requirements
- R1: After the synchronous active-low reset `rst_n`, `rd_code` reads `4'b1010` (unmasked), `rst_req` is 0 and `sts_tmo` is 0.
- R2: A platform-clock write of `4'b0101` stores `4'b0101`, and `rd_code` shows it after the write edge.
- R3: A write of any other 4-bit value stores `4'b1010`, and `rd_code` never holds a code other than `4'b0101` or `4'b1010`.
- R4: While the reset is unmasked at the gate, a rising edge of `wdt_tmo` sampled on a peripheral clock edge sets `rst_req` at that same edge.
- R5: While the reset is masked at the gate, a rising edge of `wdt_tmo` leaves `rst_req` at 0.
- R6: Every rising edge of `wdt_tmo` sets the timeout event flag, masked or not. `sts_tmo` shows the flag within two platform clock edges.
- R7: Once set, `sts_tmo` stays 1 through mask writes and through `wdt_tmo` falling. Only `rst_n` clears it.
- R8: A mask change has no effect at the gate until two platform edges and then two peripheral edges have passed after the write edge. It is in effect after two platform edges plus three peripheral edges.
- R9: A `wdt_tmo` level still high when the mask is lifted does not raise `rst_req`. A new rising edge is needed.
- R10: Once `rst_req` is 1, it stays 1 through any mask write or timeout activity until `rst_n`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_plat | input | 1 | Platform clock; mask register and status readback |
| clk_per | input | 1 | Peripheral clock; timeout gate and reset request |
| rst_n | input | 1 | Synchronous active-low hardware reset, seen by both domains |
| wr_en | input | 1 | Mask code write strobe (platform domain) |
| wr_data | input | 4 | Mask code written; `4'b0101` masks, anything else is stored as `4'b1010` |
| rd_code | output | 4 | Stored mask code |
| sts_tmo | output | 1 | Sticky timeout event flag, platform domain |
| wdt_tmo | input | 1 | Watchdog timeout level (peripheral domain) |
| rst_req | output | 1 | Registered system reset request, held until `rst_n` |

## Verification
Two functions can land in the same cycle: a mask write, and a timeout edge that arrives while the new mask decision is still in the synchronizer chain. The bench writes the masking code and raises `wdt_tmo` at the next peripheral edge. Because the old unmasked decision still governs, it expects `rst_req` to rise and the event flag to be set by that one edge. A second pair of runs does the same with the mask being lifted, where the still-masked gate must hold `rst_req` low. It also waits past the latency bound in each direction to confirm that the new setting has taken over.

// File: rtl/wdm_pkg.sv
// Package wdm_pkg
// Shared constants for the keyed watchdog reset gate: code width, the two
// legal mask codes and the synchronizer depths of each crossing.
package wdm_pkg;
    localparam int CODE_W = 4;
    localparam logic [CODE_W-1:0] CODE_MASK = 4'b0101;
    localparam logic [CODE_W-1:0] CODE_PASS = 4'b1010;
    localparam int PLAT_STAGES = 2;
    localparam int PER_STAGES  = 2;
    localparam int STS_STAGES  = 2;
endpackage

// File: rtl/wdm_sync.sv
// Module wdm_sync
// A chain of STAGES flops that carries a single bit into the clock domain of clk.
// Assumes the input is a level that holds long enough for a slow receiver;
// reset loads RST_VAL into every stage.
module wdm_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // shift the input level through the stage chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/wdm_mask_reg.sv
// Module wdm_mask_reg
// Holds the keyed mask code in the platform domain. A write of the masking
// code stores it; any other value is stored as the pass code. Assumes wr_en
// is synchronous to clk. Drives the decoded mask request level.
module wdm_mask_reg
    import wdm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_data,
    output logic [CODE_W-1:0] code,
    output logic              mask_req
);
    logic [CODE_W-1:0] code_q;

    // store the written code, coerced to one of the two legal values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= CODE_PASS;
        end else if (wr_en) begin
            code_q <= (wr_data == CODE_MASK) ? CODE_MASK : CODE_PASS;
        end
    end

    assign code     = code_q;
    assign mask_req = (code_q == CODE_MASK);
endmodule

// File: rtl/wdm_gate.sv
// Module wdm_gate
// Peripheral-domain gate. It detects rising edges of the watchdog timeout
// level, sets a sticky event flag on every edge, and raises a sticky reset
// request on an edge seen while the synchronized mask is clear. Assumes
// mask_eff is already synchronous to clk.
module wdm_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic tmo,
    input  logic mask_eff,
    output logic evt_sts,
    output logic req
);
    logic tmo_d;
    logic sts_q;
    logic req_q;
    logic tmo_edge;

    assign tmo_edge = tmo & ~tmo_d;

    // remember the previous timeout level for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) tmo_d <= 1'b0;
        else        tmo_d <= tmo;
    end

    // sticky event flag, set by any timeout edge
    always_ff @(posedge clk) begin
        if (!rst_n)        sts_q <= 1'b0;
        else if (tmo_edge) sts_q <= 1'b1;
    end

    // sticky reset request, set only by an unmasked timeout edge
    always_ff @(posedge clk) begin
        if (!rst_n)                    req_q <= 1'b0;
        else if (tmo_edge && !mask_eff) req_q <= 1'b1;
    end

    assign evt_sts = sts_q;
    assign req     = req_q;
endmodule

// File: rtl/wdm_keyed_gate.sv
// Module wdm_keyed_gate
// Top of the keyed watchdog reset gate. The mask register lives in the
// platform domain; its decision passes through platform stages and then
// peripheral stages to the gate. The sticky event flag returns to the
// platform domain for readback. Assumes rst_n is synchronous to both clocks
// and held across several edges of the slower one.
module wdm_keyed_gate
    import wdm_pkg::*;
(
    input  logic              clk_plat,
    input  logic              clk_per,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_data,
    output logic [CODE_W-1:0] rd_code,
    output logic              sts_tmo,
    input  logic              wdt_tmo,
    output logic              rst_req
);
    logic mask_req;
    logic mask_plat;
    logic mask_eff;
    logic evt_per;

    wdm_mask_reg u_reg (
        .clk      (clk_plat),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .code     (rd_code),
        .mask_req (mask_req)
    );

    wdm_sync #(.STAGES(PLAT_STAGES), .RST_VAL(1'b0)) u_plat_dly (
        .clk   (clk_plat),
        .rst_n (rst_n),
        .d     (mask_req),
        .q     (mask_plat)
    );

    wdm_sync #(.STAGES(PER_STAGES), .RST_VAL(1'b0)) u_per_sync (
        .clk   (clk_per),
        .rst_n (rst_n),
        .d     (mask_plat),
        .q     (mask_eff)
    );

    wdm_gate u_gate (
        .clk      (clk_per),
        .rst_n    (rst_n),
        .tmo      (wdt_tmo),
        .mask_eff (mask_eff),
        .evt_sts  (evt_per),
        .req      (rst_req)
    );

    wdm_sync #(.STAGES(STS_STAGES), .RST_VAL(1'b0)) u_sts_sync (
        .clk   (clk_plat),
        .rst_n (rst_n),
        .d     (evt_per),
        .q     (sts_tmo)
    );
endmodule

// File: rtl/wdm_keyed_gate_chk.sv
// Module wdm_keyed_gate_chk
// Property checker for wdm_keyed_gate, bound to every instance of the top.
module wdm_keyed_gate_chk
    import wdm_pkg::*;
(
    input logic              clk_plat,
    input logic              clk_per,
    input logic              rst_n,
    input logic              wr_en,
    input logic [CODE_W-1:0] wr_data,
    input logic [CODE_W-1:0] rd_code,
    input logic              sts_tmo,
    input logic              wdt_tmo,
    input logic              rst_req
);
    logic per_up;

    // marks peripheral cycles that have a post-reset predecessor
    always_ff @(posedge clk_per) per_up <= rst_n;

    a_r1_code_after_reset: assert property (@(posedge clk_plat)
        !rst_n |=> (rd_code == CODE_PASS));
    a_r1_req_after_reset: assert property (@(posedge clk_per)
        !rst_n |=> !rst_req);
    a_r2_mask_code_kept: assert property (@(posedge clk_plat) disable iff (!rst_n)
        (wr_en && wr_data == CODE_MASK) |=> (rd_code == CODE_MASK));
    a_r3_other_coerced: assert property (@(posedge clk_plat) disable iff (!rst_n)
        (wr_en && wr_data != CODE_MASK) |=> (rd_code == CODE_PASS));
    a_r3_code_legal: assert property (@(posedge clk_plat) disable iff (!rst_n)
        (rd_code == CODE_MASK) || (rd_code == CODE_PASS));
    a_r4_req_from_timeout: assert property (@(posedge clk_per) disable iff (!rst_n)
        (per_up && $rose(rst_req)) |-> $past(wdt_tmo));
    a_r7_status_sticky: assert property (@(posedge clk_plat) disable iff (!rst_n)
        sts_tmo |=> sts_tmo);
    a_r10_req_sticky: assert property (@(posedge clk_per) disable iff (!rst_n)
        rst_req |=> rst_req);
endmodule

bind wdm_keyed_gate wdm_keyed_gate_chk u_chk (.*);

// File: tb/tb_wdm_keyed_gate.sv
// Bench tb_wdm_keyed_gate: scoreboard with a driver pushing expectations and
// a monitor comparing them against the ports.
module tb_wdm_keyed_gate;
    logic       clk_plat = 1'b0;
    logic       clk_per  = 1'b0;
    logic       rst_n    = 1'b0;
    logic       wr_en    = 1'b0;
    logic [3:0] wr_data  = 4'h0;
    logic       wdt_tmo  = 1'b0;
    logic [3:0] rd_code;
    logic       sts_tmo;
    logic       rst_req;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    int         kq[$];
    logic [3:0] eq[$];
    string      rq[$];
    event       chk_ev;

    always #4  clk_plat = ~clk_plat;   // 125 MHz
    always #12 clk_per  = ~clk_per;    // one third, edges aligned

    wdm_keyed_gate dut (
        .clk_plat (clk_plat),
        .clk_per  (clk_per),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .rd_code  (rd_code),
        .sts_tmo  (sts_tmo),
        .wdt_tmo  (wdt_tmo),
        .rst_req  (rst_req)
    );

    // kinds: 0 = rd_code, 1 = rst_req, 2 = sts_tmo
    task automatic expect_now(input int kind, input logic [3:0] ev, input string req);
        kq.push_back(kind);
        eq.push_back(ev);
        rq.push_back(req);
        -> chk_ev;
        #1;
    endtask

    task automatic drain();
        while (kq.size() > 0) begin
            int         k = kq.pop_front();
            logic [3:0] e = eq.pop_front();
            string      r = rq.pop_front();
            logic [3:0] a;
            case (k)
                0:       a = rd_code;
                1:       a = {3'b000, rst_req};
                default: a = {3'b000, sts_tmo};
            endcase
            n_cmp++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s: kind %0d actual %h expected %h", r, k, a, e);
            end
        end
    endtask

    // monitor: compare queued expectations at the moment they are posted
    initial forever begin
        @(chk_ev);
        drain();
    end

    task automatic pneg(input int n);
        repeat (n) @(negedge clk_plat);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; wdt_tmo = 1'b0;
        repeat (4) @(negedge clk_per);
        rst_n = 1'b1;
        pneg(1);
    endtask

    task automatic write_code(input logic [3:0] v);
        @(negedge clk_plat);
        wr_en = 1'b1; wr_data = v;
        @(negedge clk_plat);
        wr_en = 1'b0;
    endtask

    task automatic set_tmo(input logic v);
        @(negedge clk_per);
        wdt_tmo = v;
    endtask

    task automatic after_per_edge();
        @(posedge clk_per);
        @(negedge clk_plat);
    endtask

    initial begin
        do_reset();
        expect_now(0, 4'hA, "R1");
        expect_now(1, 4'h0, "R1");
        expect_now(2, 4'h0, "R1");

        for (int v = 0; v < 16; v++) begin
            write_code(4'(v));
            if (v == 5) expect_now(0, 4'h5, "R2");
            else        expect_now(0, 4'hA, "R3");
        end

        // unmasked timeout (last write left the pass code)
        pneg(20);
        set_tmo(1'b1);
        expect_now(1, 4'h0, "R4");
        after_per_edge();
        expect_now(1, 4'h1, "R4");
        pneg(3);
        expect_now(2, 4'h1, "R6");
        set_tmo(1'b0);
        write_code(4'h5);
        pneg(40);
        expect_now(1, 4'h1, "R10");

        // masked timeout, then pending level across unmask
        do_reset();
        write_code(4'h5);
        pneg(30);
        set_tmo(1'b1);
        after_per_edge();
        expect_now(1, 4'h0, "R5");
        pneg(15);
        expect_now(1, 4'h0, "R5");
        expect_now(2, 4'h1, "R6");
        write_code(4'hC);
        expect_now(0, 4'hA, "R3");
        pneg(30);
        expect_now(1, 4'h0, "R9");
        set_tmo(1'b0);
        pneg(20);
        expect_now(2, 4'h1, "R7");
        set_tmo(1'b1);
        after_per_edge();
        expect_now(1, 4'h1, "R9");
        expect_now(2, 4'h1, "R7");

        do_reset();
        expect_now(2, 4'h0, "R7");
        expect_now(1, 4'h0, "R1");

        // latency: mask write and timeout close together, old decision holds
        write_code(4'h5);
        set_tmo(1'b1);
        after_per_edge();
        expect_now(1, 4'h1, "R8");
        pneg(3);
        expect_now(2, 4'h1, "R8");

        // latency: mask in force after the bound
        do_reset();
        write_code(4'h5);
        pneg(10);
        set_tmo(1'b1);
        after_per_edge();
        expect_now(1, 4'h0, "R8");
        set_tmo(1'b0);
        pneg(6);
        // lift the mask and time out at once: still masked
        write_code(4'h9);
        set_tmo(1'b1);
        after_per_edge();
        expect_now(1, 4'h0, "R8");
        set_tmo(1'b0);
        pneg(12);
        set_tmo(1'b1);
        after_per_edge();
        expect_now(1, 4'h1, "R8");

        drain();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end

    // watchdog for a hung run
    initial begin
        repeat (100000) @(posedge clk_plat);
        if (!done) begin
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end
endmodule